// File: doc/BRIEF.md
# CDMA Spread-Spectrum Bus Encoder

This block takes one 32-bit word from a bus master and turns it into four short integers that travel over a 4-bit coded bus. The word is cut into four byte-wide lanes. On each of eight encode cycles the block takes the next bit of every lane and XORs it with a bit of a spreading code. The code comes from an on-chip 8-bit linear feedback shift register. For every lane it counts the chips that come out as 1. After eight cycles each lane has a count between 0 and 8. The four counts are then sent one per cycle, lane 0 first.

The shift register is reloaded with a fixed nonzero seed each time a word is accepted. A receiver that knows the seed can therefore rebuild the same code sequence for every word. The input uses a valid/ready handshake. Ready stays low from acceptance until the last lane count has been sent. The output has a valid strobe and a start-of-word marker that flags the lane-0 count.

Top module: `spread_bus_encoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `code_valid` and `code_sow` are 0.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle and returns to 1 exactly 12 cycles after the accepting edge, once the lane-3 count has been sent.
- R3: The first count appears 8 cycles after the accepting edge. `code_valid` is then 1 for exactly four consecutive cycles per word.
- R4: `code_sow` is 1 only in the first of the four valid cycles, the one that carries lane 0.
- R5: Lane L is bits 8L+7..8L of the word. Its count is the number of k in 0..7 for which word bit 8L+k XOR code bit 2L of step k equals 1. The code for step 0 is the seed 8'hA5. Each next code is the previous one shifted up one place, with bit 0 filled by the XOR of bits 0, 1, 2 and 6.
- R6: Every count on `code_sum` lies in 0..8.
- R7: The counts are sent in lane order 0, 1, 2, 3 on consecutive cycles.
- R8: The code is reseeded for every word, so the same word sent twice gives the same four counts.
- R9: For the bitwise complement of a word, each lane count is 8 minus the count of the original word.
- R10: `in_valid` while `in_ready` is 0 is ignored. It neither changes the counts of the word in flight nor starts a further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Word to encode |
| in_valid | input | 1 | Word on `in_data` is offered |
| in_ready | output | 1 | Encoder is idle and will take a word |
| code_sum | output | 4 | Lane count on the coded bus (0 when not valid) |
| code_valid | output | 1 | `code_sum` carries a lane count |
| code_sow | output | 1 | This count is lane 0 of a new word |

## Verification
Each result has a fixed due cycle, counted from the accepting edge. Ready falls one cycle later. The lane-0 count and start marker are due after the eighth edge, lane 3 after the eleventh, and ready returns after the twelfth. The bench drives inputs and samples outputs only on falling edges. It counts the falling edges from the accept: at the seventh it confirms that nothing is valid yet, then compares each lane at its own falling edge. The expected counts come from a code-sequence model in the bench.

// File: rtl/spread_pkg.sv
package spread_pkg;

  // Width of the spreading-code register, which is also the bit width of each lane
  localparam int CODE_W = 8;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SPREAD = 2'd1,
    PH_SEND   = 2'd2
  } phase_t;

  // One step of the code generator: shift towards the top, feed the parity of the tapped stages into bit 0
  function automatic code_t code_step(code_t s, code_t taps);
    return {s[CODE_W-2:0], ^(s & taps)};
  endfunction

  // A single spread chip
  function automatic logic spread_chip(logic d, logic c);
    return d ^ c;
  endfunction

endpackage

// File: rtl/code_lfsr.sv
module code_lfsr
  import spread_pkg::*;
#(
  parameter code_t SEED = 8'hA5,
  parameter code_t TAPS = 8'h47
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  step_i,
  output code_t code_o
);

  code_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (load_i) begin
      state_q <= SEED;
    end else if (step_i) begin
      state_q <= code_step(state_q, TAPS);
    end
  end

  // All stages are read in parallel as the code word of the current step
  assign code_o = state_q;

endmodule

// File: rtl/lane_accum.sv
module lane_accum #(
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             chip_i,
  output logic [SUM_W-1:0] sum_o
);

  logic [SUM_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_q + SUM_W'(chip_i);
    end
  end

  assign sum_o = acc_q;

endmodule

// File: rtl/sum_serializer.sv
module sum_serializer #(
  parameter int LANES  = 4,
  parameter int SUM_W  = 4,
  parameter int LSEL_W = 2
) (
  input  logic [LANES-1:0][SUM_W-1:0] sums_i,
  input  logic [LSEL_W-1:0]           lane_sel_i,
  input  logic                        active_i,
  output logic [SUM_W-1:0]            sum_o,
  output logic                        valid_o,
  output logic                        sow_o
);

  always_comb begin
    sum_o   = '0;
    valid_o = active_i;
    sow_o   = active_i && (lane_sel_i == '0);
    if (active_i) begin
      sum_o = sums_i[lane_sel_i];
    end
  end

endmodule

// File: rtl/spread_bus_encoder.sv
module spread_bus_encoder
  import spread_pkg::*;
#(
  parameter int    LANES = 4,
  parameter code_t SEED  = 8'hA5,
  parameter code_t TAPS  = 8'h47,
  localparam int   LANE_W = CODE_W,
  localparam int   WORD_W = LANES * LANE_W,
  localparam int   SUM_W  = $clog2(LANE_W + 1),
  localparam int   CIDX_W = $clog2(LANE_W),
  localparam int   LSEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int   CODE_STRIDE = CODE_W / LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [SUM_W-1:0]  code_sum,
  output logic              code_valid,
  output logic              code_sow
);

  phase_t              phase_q;
  logic [CIDX_W-1:0]   chip_idx_q;
  logic [LSEL_W-1:0]   lane_idx_q;
  logic [WORD_W-1:0]   word_q;
  code_t               code;

  // Named events for the checker
  logic accept_evt;
  logic spread_done_evt;
  logic send_done_evt;
  logic spreading;
  logic sending;

  assign in_ready        = (phase_q == PH_IDLE);
  assign accept_evt      = in_valid && in_ready;
  assign spreading       = (phase_q == PH_SPREAD);
  assign sending         = (phase_q == PH_SEND);
  assign spread_done_evt = spreading && (chip_idx_q == CIDX_W'(LANE_W - 1));
  assign send_done_evt   = sending && (lane_idx_q == LSEL_W'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      chip_idx_q <= '0;
      lane_idx_q <= '0;
      word_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (accept_evt) begin
            phase_q    <= PH_SPREAD;
            chip_idx_q <= '0;
            word_q     <= in_data;
          end
        end
        PH_SPREAD: begin
          chip_idx_q <= chip_idx_q + CIDX_W'(1);
          if (spread_done_evt) begin
            phase_q    <= PH_SEND;
            lane_idx_q <= '0;
          end
        end
        PH_SEND: begin
          lane_idx_q <= lane_idx_q + LSEL_W'(1);
          if (send_done_evt) begin
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  code_lfsr #(
    .SEED (SEED),
    .TAPS (TAPS)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_evt),
    .step_i (spreading),
    .code_o (code)
  );

  logic [LANES-1:0][SUM_W-1:0] lane_sums;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_bits;
    logic              chip;

    assign lane_bits = word_q[l*LANE_W +: LANE_W];
    assign chip      = spread_chip(lane_bits[chip_idx_q], code[l*CODE_STRIDE]);

    lane_accum #(
      .SUM_W (SUM_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept_evt),
      .en_i   (spreading),
      .chip_i (chip),
      .sum_o  (lane_sums[l])
    );
  end

  sum_serializer #(
    .LANES  (LANES),
    .SUM_W  (SUM_W),
    .LSEL_W (LSEL_W)
  ) u_ser (
    .sums_i     (lane_sums),
    .lane_sel_i (lane_idx_q),
    .active_i   (sending),
    .sum_o      (code_sum),
    .valid_o    (code_valid),
    .sow_o      (code_sow)
  );

endmodule

// File: rtl/spread_bus_encoder_chk.sv
module spread_bus_encoder_chk #(
  parameter int SUM_W   = 4,
  parameter int MAX_SUM = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             accept_evt,
  input logic             spread_done_evt,
  input logic [SUM_W-1:0] code_sum,
  input logic             code_valid,
  input logic             code_sow
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> !in_ready); // R2

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !in_ready); // R2

  AST_READY_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(code_valid) |-> in_ready); // R2

  AST_SPREAD_TO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    spread_done_evt |=> (code_valid && code_sow)); // R3

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (code_sum <= SUM_W'(MAX_SUM))); // R6

  AST_SOW_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_valid) |-> code_sow); // R4

  AST_SOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_sow |=> !code_sow); // R4

  AST_SOW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    code_sow |-> code_valid); // R4

endmodule

bind spread_bus_encoder spread_bus_encoder_chk #(
  .SUM_W   (SUM_W),
  .MAX_SUM (LANE_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_ready        (in_ready),
  .accept_evt      (accept_evt),
  .spread_done_evt (spread_done_evt),
  .code_sum        (code_sum),
  .code_valid      (code_valid),
  .code_sow        (code_sow)
);

// File: tb/spread_bus_encoder_tb.sv
module spread_bus_encoder_tb;

  localparam logic [7:0] SEED = 8'hA5;
  localparam int NSTIM = 8;
  localparam logic [31:0] STIM [NSTIM] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF,
    32'h00FF_00FF, 32'hA5A5_5A5A, 32'h8000_0001, 32'h0F0F_F0F0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  code_sum;
  logic        code_valid;
  logic        code_sow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spread_bus_encoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .code_sum   (code_sum),
    .code_valid (code_valid),
    .code_sow   (code_sow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model of the lane counts, R5
  function automatic logic [15:0] model(input logic [31:0] w);
    logic [7:0] c;
    logic [3:0] cnt [4];
    logic       fb;
    c = SEED;
    for (int l = 0; l < 4; l++) cnt[l] = 4'd0;
    for (int k = 0; k < 8; k++) begin
      for (int l = 0; l < 4; l++) begin
        if (w[8*l + k] != c[2*l]) cnt[l] = cnt[l] + 4'd1;
      end
      fb = c[0] ^ c[1] ^ c[2] ^ c[6];
      c  = (c << 1) | {7'd0, fb};
    end
    return {cnt[3], cnt[2], cnt[1], cnt[0]};
  endfunction

  // Offers w, follows the burst and returns the four counts seen; optional interference during the busy phase
  task automatic run_word(input logic [31:0] w, input logic [15:0] exp, input bit disturb,
                          output logic [15:0] got);
    got = '0;
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    chk("R2 ready before accept", {31'd0, in_ready}, 32'd1);
    @(negedge clk);           // the accepting edge lies just before this sample
    in_valid = 1'b0;
    chk("R2 ready low after accept", {31'd0, in_ready}, 32'd0);
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (disturb && n == 3) begin
        in_data  = ~w;
        in_valid = 1'b1;
      end
    end
    chk("R3 no count before cycle 8", {31'd0, code_valid}, 32'd0);
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      if (disturb && l == 3) in_valid = 1'b0;
      chk("R3 valid during burst", {31'd0, code_valid}, 32'd1);
      chk("R4 start marker", {31'd0, code_sow}, (l == 0) ? 32'd1 : 32'd0);
      chk("R5 R7 lane count", {28'd0, code_sum}, {28'd0, exp[4*l +: 4]});
      chk("R6 count range", {31'd0, (code_sum <= 4'd8)}, 32'd1);
      chk("R2 busy while sending", {31'd0, in_ready}, 32'd0);
      got[4*l +: 4] = code_sum;
    end
    @(negedge clk);
    chk("R3 burst is four cycles", {31'd0, code_valid}, 32'd0);
    chk("R2 ready back after 12 cycles", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] got_a;
    logic [15:0] got_b;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, in_ready}, 32'd1);
    chk("R1 valid in reset", {31'd0, code_valid}, 32'd0);
    chk("R1 sow in reset", {31'd0, code_sow}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, in_ready, code_valid, code_sow}, 32'b100);

    for (int i = 0; i < NSTIM; i++) begin
      run_word(STIM[i], model(STIM[i]), 1'b0, got_a);
    end

    // R8: same word twice gives the same counts
    run_word(32'hC3A1_7E09, model(32'hC3A1_7E09), 1'b0, got_a);
    run_word(32'hC3A1_7E09, model(32'hC3A1_7E09), 1'b0, got_b);
    chk("R8 reseed repeat", {16'd0, got_b}, {16'd0, got_a});

    // R9: complement gives 8 minus each count
    run_word(~32'hC3A1_7E09, model(~32'hC3A1_7E09), 1'b0, got_b);
    for (int l = 0; l < 4; l++) begin
      chk("R9 complement lane", {28'd0, got_b[4*l +: 4]}, {28'd0, 4'd8 - got_a[4*l +: 4]});
    end

    // R10: offers during the busy phase are ignored
    run_word(32'h5566_7788, model(32'h5566_7788), 1'b1, got_a);
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      chk("R10 no extra burst", {31'd0, code_valid}, 32'd0);
    end

    // R1: reset in the middle of a word returns to idle
    @(negedge clk);
    in_data  = 32'h1111_2222;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-word reset", {29'd0, in_ready, code_valid, code_sow}, 32'b100);
    rst_n = 1'b1;
    run_word(32'h1111_2222, model(32'h1111_2222), 1'b0, got_a);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule